// File: doc/BRIEF.md
# Endpoint FIFO Space Allocator

This block hands out regions of a shared endpoint FIFO buffer. The buffer is divided into 512-byte units, and a 128-bit occupancy map records which units are taken. An allocate request supplies the endpoint's maximum packet size and a slot count. The block rounds the packet size up to a power of two to get the segment size, multiplies it by the slot count plus one, and converts the result into whole units. It then searches the map from unit 0 upward, testing one candidate start per clock. At the first run of free units that is long enough it marks the run as used and returns its byte address. A free request gives back an address together with the same packet size and slot count, and the block clears that run.

One instance serves the transmit buffer and another serves the receive buffer. Software normally passes a slot count of 2 on a SuperSpeed-capable controller and 1 on a high-speed-only one. The block itself treats the slot count as an ordinary input. An input sets how many map bits are valid, so a smaller buffer can reuse the same logic. Only one request is in flight at a time.

Top module: `fifo_space_alloc`

## Requirements
- R1: After reset the map is empty, and `busy`, `done`, `fail` and `err` are low.
- R2: The unit count equals ceil(S / 512), where S = P × (slot + 1) and P is the smallest power of two not below the packet size (a size of 0 counts as 1). The count is never below one, and it is reported on `rsp_units` while `done` is high.
- R3: An allocation takes the lowest start index whose run of units is entirely free. It returns `rsp_addr` = base + index × 512 and marks exactly those units as used.
- R4: When no run fits, the allocation ends with `fail` high, and the occupancy map is unchanged.
- R5: No unit at or above `map_limit` is ever allocated.
- R6: A valid free (`req_free`=1) clears exactly the units of its run, and those units can be allocated again.
- R7: A free ends with `err` high and changes nothing if any of these holds: the offset from base is not a multiple of 512, the run reaches `map_limit` or beyond, or any unit of the run is not currently allocated.
- R8: `done` is a one-cycle pulse. Counting from the accepting clock edge, an allocation found at index i completes i+1 cycles later, a failing allocation completes limit−units+2 cycles later (1 cycle when units exceed the limit), and a free completes after 1 cycle. `busy` is high in between.
- R9: Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | ADDR_W | Byte address of unit 0 |
| map_limit | input | LIM_W | Number of valid map units (held stable outside reset) |
| req_valid | input | 1 | Request present; taken when idle |
| req_free | input | 1 | 0 = allocate, 1 = free |
| req_maxp | input | MAXP_W | Endpoint maximum packet size in bytes |
| req_slot | input | SLOT_W | Slot count |
| req_addr | input | ADDR_W | Byte address to release (free only) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With done: allocation found no room |
| err | output | 1 | With done: free rejected |
| rsp_addr | output | ADDR_W | With done: allocated byte address |
| rsp_units | output | CNT_W | With done: unit count of the request |

## Verification
The bench checks the size arithmetic against every packet size and every slot count. A wrong rounding would show up as an incorrect unit count near power-of-two boundaries and near multiples of 512. It fills a small buffer completely, so an off-by-one in the limit test would either place a run past the limit or report failure one candidate too early. The observed latency also exposes a search that skips or repeats candidates. Double frees, misaligned frees and out-of-range frees must be rejected without side effects; a design that cleared bits anyway would later hand out space that is still in use. A request held high during a long search must not be taken, or the next allocation would succeed where it has to fail.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_FREE   = 2'd2
    } fsa_state_e;

    typedef struct packed {
        logic done;
        logic fail;
        logic err;
    } fsa_flags_t;

    // Smallest power of two that is not below x; x = 0 yields 1.
    function automatic logic [31:0] ceil_pow2(input logic [31:0] x);
        logic [31:0] r;
        r = 32'd1;
        for (int i = 0; i < 31; i++) begin
            if (r < x) r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fsa_sizer.sv
module fsa_sizer #(
    parameter int MAXP_W  = 11,
    parameter int SLOT_W  = 2,
    parameter int UNIT_LG = 9,
    parameter int CNT_W   = 6
) (
    input  logic [MAXP_W-1:0] maxp,
    input  logic [SLOT_W-1:0] slot,
    output logic [CNT_W-1:0]  units
);
    localparam int SEG_W = MAXP_W + 1 + SLOT_W;

    logic [MAXP_W:0]  seg_base;
    logic [SLOT_W:0]  slot_mul;
    logic [SEG_W-1:0] seg_bytes;

    assign seg_base  = (MAXP_W+1)'(fsa_pkg::ceil_pow2(32'(maxp)));
    assign slot_mul  = (SLOT_W+1)'(slot) + (SLOT_W+1)'(1);
    assign seg_bytes = SEG_W'(seg_base) * SEG_W'(slot_mul);
    // Whole units plus one for any partial remainder (seg_bytes >= 1 always).
    assign units = CNT_W'(seg_bytes[SEG_W-1:UNIT_LG]) + CNT_W'(|seg_bytes[UNIT_LG-1:0]);

endmodule

// File: rtl/fsa_window.sv
module fsa_window #(
    parameter int MAP_BITS = 128,
    parameter int LIM_W    = 8,
    parameter int CNT_W    = 6
) (
    input  logic [MAP_BITS-1:0] map,
    input  logic [LIM_W-1:0]    idx,
    input  logic [LIM_W-1:0]    limit,
    input  logic [CNT_W-1:0]    units,
    output logic [MAP_BITS-1:0] mask,
    output logic                in_range,
    output logic                is_clear,
    output logic                is_full
);
    localparam int W = ((LIM_W > CNT_W) ? LIM_W : CNT_W) + 1;

    logic [W-1:0] lo;
    logic [W-1:0] hi;

    assign lo = W'(idx);
    assign hi = lo + W'(units);

    for (genvar i = 0; i < MAP_BITS; i++) begin : g_bit
        assign mask[i] = (W'(i) >= lo) && (W'(i) < hi);
    end

    assign in_range = (hi <= W'(limit));
    assign is_clear = ((map & mask) == '0);
    assign is_full  = ((map & mask) == mask);

    // R2: an in-range window spans exactly the requested unit count
    always_comb begin
        if (in_range) begin
            a_window_len_r2: assert ($countones(mask) == int'(units))
                else $error("window length differs from unit count");
        end
    end

endmodule

// File: rtl/fsa_map.sv
module fsa_map #(
    parameter int MAP_BITS = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [MAP_BITS-1:0] mask,
    output logic [MAP_BITS-1:0] map_q
);
    always_ff @(posedge clk) begin
        if (rst)         map_q <= '0;
        else if (set_en) map_q <= map_q | mask;
        else if (clr_en) map_q <= map_q & ~mask;
    end

    // R6: marking and releasing never happen in the same cycle
    p_one_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        !(set_en && clr_en));

    // R3: a marking step only adds bits
    p_set_adds_r3: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((map_q & $past(map_q)) == $past(map_q)));

endmodule

// File: rtl/fifo_space_alloc.sv
module fifo_space_alloc #(
    parameter int UNIT_BYTES = 512,
    parameter int MAP_BITS   = 128,
    parameter int ADDR_W     = 32,
    parameter int MAXP_W     = 11,
    parameter int SLOT_W     = 2,
    localparam int UNIT_LG   = $clog2(UNIT_BYTES),
    localparam int LIM_W     = $clog2(MAP_BITS + 1),
    localparam int SEG_W     = MAXP_W + 1 + SLOT_W,
    localparam int CNT_W     = SEG_W - UNIT_LG + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LIM_W-1:0]  map_limit,
    input  logic              req_valid,
    input  logic              req_free,
    input  logic [MAXP_W-1:0] req_maxp,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              err,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [CNT_W-1:0]  rsp_units
);
    import fsa_pkg::*;

    localparam int HI_W = ADDR_W - UNIT_LG;

    fsa_state_e        state_q;
    logic [LIM_W-1:0]  idx_q;
    logic [CNT_W-1:0]  units_q;
    logic              op_free_q;
    logic              bad_q;
    fsa_flags_t        flags_q;
    logic [ADDR_W-1:0] addr_q;

    logic [CNT_W-1:0]    sz_units;
    logic [MAP_BITS-1:0] map_q;
    logic [MAP_BITS-1:0] win_mask;
    logic                win_in_range;
    logic                win_clear;
    logic                win_full;
    logic                set_en;
    logic                clr_en;

    logic [ADDR_W-1:0] rel_off;
    logic [HI_W-1:0]   rel_hi;
    logic              rel_bad;

    fsa_sizer #(
        .MAXP_W (MAXP_W),
        .SLOT_W (SLOT_W),
        .UNIT_LG(UNIT_LG),
        .CNT_W  (CNT_W)
    ) u_sizer (
        .maxp (req_maxp),
        .slot (req_slot),
        .units(sz_units)
    );

    fsa_window #(
        .MAP_BITS(MAP_BITS),
        .LIM_W   (LIM_W),
        .CNT_W   (CNT_W)
    ) u_window (
        .map     (map_q),
        .idx     (idx_q),
        .limit   (map_limit),
        .units   (units_q),
        .mask    (win_mask),
        .in_range(win_in_range),
        .is_clear(win_clear),
        .is_full (win_full)
    );

    fsa_map #(
        .MAP_BITS(MAP_BITS)
    ) u_map (
        .clk   (clk),
        .rst   (rst),
        .set_en(set_en),
        .clr_en(clr_en),
        .mask  (win_mask),
        .map_q (map_q)
    );

    // Release address decode: unit index, alignment and coarse range.
    assign rel_off = req_addr - base_addr;
    assign rel_hi  = rel_off[ADDR_W-1:UNIT_LG];
    assign rel_bad = (|rel_off[UNIT_LG-1:0]) || (rel_hi > HI_W'(MAP_BITS));

    always_comb begin
        set_en = (state_q == ST_SEARCH) && win_in_range && win_clear;
        clr_en = (state_q == ST_FREE) && !bad_q && win_in_range && win_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            units_q   <= '0;
            op_free_q <= 1'b0;
            bad_q     <= 1'b0;
            flags_q   <= '0;
            addr_q    <= '0;
        end else begin
            flags_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        units_q   <= sz_units;
                        op_free_q <= req_free;
                        if (req_free) begin
                            idx_q   <= rel_hi[LIM_W-1:0];
                            bad_q   <= rel_bad;
                            state_q <= ST_FREE;
                        end else begin
                            idx_q   <= '0;
                            bad_q   <= 1'b0;
                            state_q <= ST_SEARCH;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (!win_in_range) begin
                        flags_q.done <= 1'b1;
                        flags_q.fail <= 1'b1;
                        state_q      <= ST_IDLE;
                    end else if (win_clear) begin
                        flags_q.done <= 1'b1;
                        addr_q       <= base_addr + (ADDR_W'(idx_q) << UNIT_LG);
                        state_q      <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + LIM_W'(1);
                    end
                end
                ST_FREE: begin
                    flags_q.done <= 1'b1;
                    flags_q.err  <= bad_q || !win_in_range || !win_full;
                    state_q      <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = flags_q.done;
    assign fail      = flags_q.fail;
    assign err       = flags_q.err;
    assign rsp_addr  = addr_q;
    assign rsp_units = units_q;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: a failed allocation leaves the map untouched
    p_fail_keeps_map_r4: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> $stable(map_q));

    // R7: a rejected release leaves the map untouched
    p_err_keeps_map_r7: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> $stable(map_q));

    // R2: a successful allocation adds exactly the unit count
    p_alloc_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !fail && !op_free_q) |->
            ($countones(map_q) == $past($countones(map_q)) + int'(units_q)));

    // R6: a successful release removes exactly the unit count
    p_free_shrinks_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !err && op_free_q) |->
            ($countones(map_q) + int'(units_q) == $past($countones(map_q))));

    // R5: nothing at or above the limit is ever marked
    p_within_limit_r5: assert property (@(posedge clk) disable iff (rst)
        ((map_q >> map_limit) == '0));

endmodule

// File: tb/fifo_space_alloc_bench.sv
`timescale 1ns/1ps
module fifo_space_alloc_bench;

    localparam int ADDR_W = 32;
    localparam int MAXP_W = 11;
    localparam int SLOT_W = 2;
    localparam int LIM_W  = 8;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [LIM_W-1:0]  map_limit = 8'd128;
    logic              req_valid = 1'b0;
    logic              req_free = 1'b0;
    logic [MAXP_W-1:0] req_maxp = '0;
    logic [SLOT_W-1:0] req_slot = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              busy, done, fail, err;
    logic [ADDR_W-1:0] rsp_addr;
    logic [CNT_W-1:0]  rsp_units;

    int  n_checks = 0;
    int  n_errors = 0;
    int  cycles = 0;
    bit  refmap [128];
    int  live_idx [64];
    int  live_maxp [64];
    int  live_slot [64];
    int  n_live = 0;
    logic [15:0] lfsr = 16'hACE1;

    fifo_space_alloc u_fifo_space_alloc (
        .clk(clk), .rst(rst), .base_addr(base_addr), .map_limit(map_limit),
        .req_valid(req_valid), .req_free(req_free), .req_maxp(req_maxp),
        .req_slot(req_slot), .req_addr(req_addr), .busy(busy), .done(done),
        .fail(fail), .err(err), .rsp_addr(rsp_addr), .rsp_units(rsp_units)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_errors = n_errors + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog act=%0d exp=<190000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    function automatic int exp_units(input int maxp, input int slot);
        int p = 1;
        while (p < maxp) p = p * 2;
        return (p * (slot + 1) + 511) / 512;
    endfunction

    function automatic void step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endfunction

    task automatic do_reset(input int lim, input logic [31:0] base);
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        map_limit = LIM_W'(lim);
        base_addr = base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 128; i++) refmap[i] = 1'b0;
        n_live = 0;
        @(negedge clk);
        chk(!busy && !done && !fail && !err, "R1 idle after reset", {busy, done, fail, err}, 0);
    endtask

    // Issue one request; optionally hold a conflicting release during the search (R9).
    task automatic issue(input bit fr, input int maxp, input int slot,
                         input logic [31:0] addr, input bit hold, output int cnt);
        @(negedge clk);
        req_valid = 1'b1;
        req_free = fr;
        req_maxp = MAXP_W'(maxp);
        req_slot = SLOT_W'(slot);
        req_addr = addr;
        @(posedge clk);
        @(negedge clk);
        if (hold) begin
            req_free = 1'b1;
            req_addr = base_addr;
        end else begin
            req_valid = 1'b0;
        end
        chk(busy, "R8 busy after accept", busy, 1);
        cnt = 0;
        while (cnt < 400) begin
            @(negedge clk);
            cnt++;
            if (done) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic do_alloc(input int maxp, input int slot, input bit hold, output int got);
        int eu, lim, ei, ecnt, cnt;
        bit okrun;
        eu = exp_units(maxp, slot);
        lim = int'(map_limit);
        ei = -1;
        for (int s = 0; s + eu <= lim; s++) begin
            okrun = 1'b1;
            for (int k = 0; k < eu; k++) if (refmap[s + k]) okrun = 1'b0;
            if (okrun) begin ei = s; break; end
        end
        if (ei >= 0) ecnt = ei + 1;
        else if (eu > lim) ecnt = 1;
        else ecnt = lim - eu + 2;
        issue(1'b0, maxp, slot, '0, hold, cnt);
        chk(done, "R8 done seen", done, 1);
        chk(int'(rsp_units) == eu, "R2 unit count", rsp_units, eu);
        chk(cnt == ecnt, "R8 latency", cnt, ecnt);
        if (ei >= 0) begin
            chk(!fail, "R3 allocation succeeds", fail, 0);
            chk(rsp_addr == base_addr + 32'(ei * 512), "R3 address", rsp_addr,
                base_addr + 32'(ei * 512));
            chk(ei + eu <= lim, "R5 within limit", ei + eu, lim);
            for (int k = 0; k < eu; k++) refmap[ei + k] = 1'b1;
        end else begin
            chk(fail, "R4 no room flags fail", fail, 1);
        end
        got = ei;
    endtask

    task automatic do_free(input logic [31:0] addr, input int maxp, input int slot);
        int eu, lim, ix, cnt;
        logic [31:0] off;
        bit eerr;
        eu = exp_units(maxp, slot);
        lim = int'(map_limit);
        off = addr - base_addr;
        eerr = (off[8:0] != 0) || (off > 32'(lim * 512));
        ix = int'(off >> 9);
        if (!eerr) begin
            if (ix + eu > lim) eerr = 1'b1;
            else for (int k = 0; k < eu; k++) if (!refmap[ix + k]) eerr = 1'b1;
        end
        issue(1'b1, maxp, slot, addr, 1'b0, cnt);
        chk(done && cnt == 1, "R8 release latency", cnt, 1);
        if (eerr) chk(err, "R7 bad release rejected", err, 1);
        else begin
            chk(!err, "R6 release accepted", err, 0);
            for (int k = 0; k < eu; k++) refmap[ix + k] = 1'b0;
        end
    endtask

    initial begin
        int got, mp, sl, k;

        // Phase 1: every packet size and slot count on an empty full-size map (R2, R3)
        do_reset(128, 32'h0002_0000);
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 2048; m++) begin
                do_alloc(m, s, 1'b0, got);
                chk(got == 0, "R3 first fit on empty map", got, 0);
                do_free(base_addr, m, s);
            end
        end

        // Phase 2: small limit, fill, overflow, reuse, bad releases
        do_reset(16, 32'h0001_0000);
        for (int i = 0; i < 16; i++) begin
            do_alloc(512, 0, 1'b0, got);
            chk(got == i, "R3 ascending placement", got, i);
        end
        do_alloc(512, 0, 1'b1, got);            // R9: release held during search
        do_alloc(512, 0, 1'b0, got);
        chk(got == -1, "R9 held request ignored", got, -1);
        do_free(base_addr + 32'(5 * 512), 512, 0);
        do_alloc(1024, 0, 1'b0, got);           // R4: two-unit run does not fit
        do_alloc(512, 0, 1'b0, got);
        chk(got == 5, "R6 freed unit reused", got, 5);
        do_free(base_addr + 32'(3 * 512), 512, 0);
        do_free(base_addr + 32'(4 * 512), 512, 0);
        do_alloc(1024, 0, 1'b0, got);
        chk(got == 3, "R6 merged run reused", got, 3);
        do_free(base_addr + 32'(20 * 512), 512, 0);   // R7: beyond limit
        do_free(base_addr + 32'd100, 512, 0);         // R7: misaligned
        do_free(base_addr, 1024, 0);                  // clears units 0 and 1
        do_free(base_addr, 512, 0);                   // R7: double release
        do_alloc(2047, 3, 1'b0, got);                 // R4: 16 units, fails
        do_alloc(256, 1, 1'b0, got);
        do_alloc(300, 1, 1'b0, got);

        // Phase 3: pseudo-random mix on limit 40
        do_reset(40, 32'h0000_4000);
        for (int n = 0; n < 400; n++) begin
            step_lfsr();
            if (n_live == 0 || lfsr[0]) begin
                mp = int'(lfsr[10:0]) >> (2 * int'(lfsr[15:14]));
                sl = int'(lfsr[3:2]);
                do_alloc(mp, sl, 1'b0, got);
                if (got >= 0 && n_live < 64) begin
                    live_idx[n_live] = got;
                    live_maxp[n_live] = mp;
                    live_slot[n_live] = sl;
                    n_live++;
                end
            end else if (lfsr[5:1] == 5'd0) begin
                do_free(base_addr + 32'((40 + int'(lfsr[8:6])) * 512), 512, 0);
            end else begin
                k = int'(lfsr[11:4]) % n_live;
                do_free(base_addr + 32'(live_idx[k] * 512), live_maxp[k], live_slot[k]);
                live_idx[k] = live_idx[n_live - 1];
                live_maxp[k] = live_maxp[n_live - 1];
                live_slot[k] = live_slot[n_live - 1];
                n_live--;
            end
        end

        // Phase 4: request larger than the whole limit, and tail fit (R5, R8)
        do_reset(8, 32'h0000_0000);
        do_alloc(2047, 3, 1'b0, got);
        chk(got == -1, "R5 oversize request fails", got, -1);
        do_alloc(512, 3, 1'b0, got);
        do_alloc(1, 0, 1'b0, got);
        chk(got == 4, "R2 one-byte request takes one unit", got, 4);
        do_alloc(1024, 1, 1'b0, got);
        chk(got == -1, "R5 run may not cross limit", got, -1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule